// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to a usable state after the system reset is released. It owns the memory command pins during start-up: clock enable, chip select, the three active-low command strobes, the bank address and the address bus. It first holds clock enable low for a long settle period, then raises it and plays a fixed, ordered series of commands: both precharges, the extended-mode load, the two main-mode loads (one with the DLL reset bit set, one with it clear) and two auto refreshes. It then waits for the DLL to lock before raising a completion flag. Calibration logic that sits downstream waits for this flag before taking over the command pins.

Every delay is counted in clock cycles, and each one is a parameter. The settle period defaults to the clock rate in MHz times 200 µs. Precharge, mode-load and refresh spacing are each set by their own parameter. Burst length, burst type, CAS latency and output drive strength are parameters that are packed into the mode words. The controller is a single enumerated state machine with these states:

- `ST_PWR_WAIT`: clock enable is low.
- `ST_CKE_SETUP`: one quiet cycle with clock enable high.
- `ST_PRE_A`, `ST_LOAD_EXT`, `ST_LOAD_DLLRST`, `ST_PRE_B`, `ST_REF_A`, `ST_REF_B`, `ST_LOAD_RUN`: one state per command step.
- `ST_DONE`: the final state.

Each state lasts exactly its dwell count. On expiry the machine moves to the next state in that list, and `ST_DONE` is never left except by reset. A reset at any point returns the machine to `ST_PWR_WAIT`. All pins are registered, so each pin lags its state by one cycle.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs are: `cke`=0, `cs_n`=1, `init_done`=0, command lines at NOP (ras_n,cas_n,we_n = 1,1,1), `ba`=0 and `addr`=0.
- R2: Count clock edges from the last edge on which `rst` was high. `cke` is low through edge PWRUP_CYCLES and is high from edge PWRUP_CYCLES+1 onward. Once high, it stays high until the next reset.
- R3: The command codes on {ras_n,cas_n,we_n} are: mode load 000, auto refresh 001, precharge 010. Every other cycle carries NOP 111. `cs_n` is the inverse of `cke`.
- R4: After `cke` rises, exactly seven commands are issued, in this order: precharge, extended-mode load, mode load with DLL reset, precharge, auto refresh, auto refresh, mode load without DLL reset.
- R5: Every precharge drives `addr[10]`=1 with all other address bits 0, and `ba`=0.
- R6: The extended-mode load drives `ba`=01. Its address has bit 0 = 0 (DLL on), bit 1 = DRV_REDUCED, and all other bits 0.
- R7: Both mode loads drive `ba`=00. The address fields are: bits 2..0 = BURST_CODE, bit 3 = BURST_TYPE, bits 6..4 = CAS_CODE, bit 8 = 1 on the first load and 0 on the second, all other bits 0.
- R8: The first precharge comes one cycle after `cke` rises. The spacing from each command to the next is: TRP_CYC, TMRD_CYC, TMRD_CYC, TRP_CYC, TRFC_CYC, TRFC_CYC.
- R9: `init_done` rises exactly LOCK_CYC cycles after the final mode load. From then until reset it stays high, with NOP on the command lines.
- R10: A reset raised in the middle of the sequence restores the R1 outputs. The next release then replays the whole sequence from the settle wait, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write-enable strobe, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Start-up complete |

## Verification
The bench runs a full clean start-up with non-default field values: burst code 011, burst type 1, CAS code 110 and reduced drive. Because every field carries a nonzero, asymmetric value, a field shifted to the wrong position or swapped with another shows up as a wrong address word. The bench logs every non-NOP cycle by edge number and compares the list against the expected commands. This separates a wrong order, a missing or extra refresh, a wrong bank, and an off-by-one in any single dwell. A second pattern raises reset after the extended-mode load. This shows whether the restart really reloads the settle counter rather than carrying on from where it stopped. A hold window after completion confirms that the flag and the quiet command lines persist.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } cmd_t;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_CKE_SETUP,
        ST_PRE_A,
        ST_LOAD_EXT,
        ST_LOAD_DLLRST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_LOAD_RUN,
        ST_DONE
    } state_t;

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
    parameter int CW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/init_mode_words.sv
module init_mode_words #(
    parameter int          ADDR_W      = 13,
    parameter logic [2:0]  BURST_CODE  = 3'b010,
    parameter logic        BURST_TYPE  = 1'b0,
    parameter logic [2:0]  CAS_CODE    = 3'b011,
    parameter logic        DRV_REDUCED = 1'b0
) (
    output logic [ADDR_W-1:0] pre_word,
    output logic [ADDR_W-1:0] ext_word,
    output logic [ADDR_W-1:0] dllrst_word,
    output logic [ADDR_W-1:0] run_word
);
    localparam int A10 = 10;
    localparam int A8  = 8;

    logic [ADDR_W-1:0] base_mode;

    always_comb begin
        pre_word       = '0;
        pre_word[A10]  = 1'b1;

        ext_word       = '0;
        ext_word[0]    = 1'b0;
        ext_word[1]    = DRV_REDUCED;

        base_mode      = '0;
        base_mode[2:0] = BURST_CODE;
        base_mode[3]   = BURST_TYPE;
        base_mode[6:4] = CAS_CODE;

        run_word       = base_mode;
        dllrst_word    = base_mode;
        dllrst_word[A8] = 1'b1;
    end
endmodule

// File: rtl/init_pin_reg.sv
module init_pin_reg #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_d,
    input  logic [2:0]        cmd_d,
    input  logic [BANK_W-1:0] ba_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              done_d,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cke       <= 1'b0;
            cs_n      <= 1'b1;
            {ras_n, cas_n, we_n} <= 3'b111;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
        end else begin
            cke       <= cke_d;
            cs_n      <= ~cke_d;
            {ras_n, cas_n, we_n} <= cmd_d;
            ba        <= ba_d;
            addr      <= addr_d;
            init_done <= done_d;
        end
    end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int          CLK_MHZ      = 200,
    parameter int          PWRUP_US     = 200,
    parameter int          PWRUP_CYCLES = CLK_MHZ * PWRUP_US,
    parameter int          TRP_CYC      = 3,
    parameter int          TMRD_CYC     = 2,
    parameter int          TRFC_CYC     = 14,
    parameter int          LOCK_CYC     = 200,
    parameter int          ADDR_W       = 13,
    parameter int          BANK_W       = 2,
    parameter logic [2:0]  BURST_CODE   = 3'b010,
    parameter logic        BURST_TYPE   = 1'b0,
    parameter logic [2:0]  CAS_CODE     = 3'b011,
    parameter logic        DRV_REDUCED  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int MAX_A = (PWRUP_CYCLES > LOCK_CYC) ? PWRUP_CYCLES : LOCK_CYC;
    localparam int MAX_B = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
    localparam int MAX_C = (MAX_B > TMRD_CYC) ? MAX_B : TMRD_CYC;
    localparam int MAXD  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CW    = $clog2(MAXD + 1);

    state_t            state_q, state_nx;
    logic              first_q;
    logic              tmr_expired;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;

    logic [ADDR_W-1:0] pre_word, ext_word, dllrst_word, run_word;

    logic              cke_c, done_c;
    cmd_t              cmd_c;
    logic [BANK_W-1:0] ba_c;
    logic [ADDR_W-1:0] addr_c;

    function automatic logic [CW-1:0] dwell_m1(state_t s);
        logic [CW-1:0] r;
        case (s)
            ST_PWR_WAIT:    r = CW'(PWRUP_CYCLES - 1);
            ST_PRE_A,
            ST_PRE_B:       r = CW'(TRP_CYC - 1);
            ST_LOAD_EXT,
            ST_LOAD_DLLRST: r = CW'(TMRD_CYC - 1);
            ST_REF_A,
            ST_REF_B:       r = CW'(TRFC_CYC - 1);
            ST_LOAD_RUN:    r = CW'(LOCK_CYC - 1);
            default:        r = '0;
        endcase
        return r;
    endfunction

    // Next-state logic: each state holds for its dwell, then advances.
    always_comb begin
        state_nx = state_q;
        if (tmr_expired) begin
            unique case (state_q)
                ST_PWR_WAIT:    state_nx = ST_CKE_SETUP;
                ST_CKE_SETUP:   state_nx = ST_PRE_A;
                ST_PRE_A:       state_nx = ST_LOAD_EXT;
                ST_LOAD_EXT:    state_nx = ST_LOAD_DLLRST;
                ST_LOAD_DLLRST: state_nx = ST_PRE_B;
                ST_PRE_B:       state_nx = ST_REF_A;
                ST_REF_A:       state_nx = ST_REF_B;
                ST_REF_B:       state_nx = ST_LOAD_RUN;
                ST_LOAD_RUN:    state_nx = ST_DONE;
                ST_DONE:        state_nx = ST_DONE;
            endcase
        end
        tmr_load = (state_nx != state_q);
        tmr_val  = dwell_m1(state_nx);
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWR_WAIT;
            first_q <= 1'b1;
        end else begin
            state_q <= state_nx;
            first_q <= (state_nx != state_q);
        end
    end

    // Output decode: command only on the first cycle of a command state
    always_comb begin
        cmd_c  = CMD_NOP;
        ba_c   = '0;
        addr_c = '0;
        cke_c  = (state_q != ST_PWR_WAIT);
        done_c = (state_q == ST_DONE);
        if (first_q) begin
            unique case (state_q)
                ST_PRE_A, ST_PRE_B: begin
                    cmd_c  = CMD_PRE;
                    addr_c = pre_word;
                end
                ST_LOAD_EXT: begin
                    cmd_c  = CMD_LMR;
                    ba_c   = BANK_W'(1);
                    addr_c = ext_word;
                end
                ST_LOAD_DLLRST: begin
                    cmd_c  = CMD_LMR;
                    addr_c = dllrst_word;
                end
                ST_LOAD_RUN: begin
                    cmd_c  = CMD_LMR;
                    addr_c = run_word;
                end
                ST_REF_A, ST_REF_B: begin
                    cmd_c  = CMD_REF;
                end
                ST_PWR_WAIT, ST_CKE_SETUP, ST_DONE: begin
                    cmd_c  = CMD_NOP;
                end
            endcase
        end
    end

    init_step_timer #(
        .CW      (CW),
        .RST_VAL (PWRUP_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    init_mode_words #(
        .ADDR_W      (ADDR_W),
        .BURST_CODE  (BURST_CODE),
        .BURST_TYPE  (BURST_TYPE),
        .CAS_CODE    (CAS_CODE),
        .DRV_REDUCED (DRV_REDUCED)
    ) u_words (
        .pre_word    (pre_word),
        .ext_word    (ext_word),
        .dllrst_word (dllrst_word),
        .run_word    (run_word)
    );

    init_pin_reg #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_pins (
        .clk       (clk),
        .rst       (rst),
        .cke_d     (cke_c),
        .cmd_d     (cmd_c),
        .ba_d      (ba_c),
        .addr_d    (addr_c),
        .done_d    (done_c),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );
endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);                                            // R2

    AST_QUIET_BEFORE_CKE: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (ras_n && cas_n && we_n));                      // R3

    AST_CS_FOLLOWS_CKE: assert property (@(posedge clk) disable iff (rst)
        cs_n != cke);                                            // R3

    AST_PRE_A10: assert property (@(posedge clk) disable iff (rst)
        ({ras_n, cas_n, we_n} == 3'b010) |-> (addr[10] && ba == '0)); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);                                // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && ras_n && cas_n && we_n));          // R9

    AST_NO_ACCESS_CMD: assert property (@(posedge clk) disable iff (rst)
        !(ras_n && !cas_n) && !(!ras_n && cas_n && we_n));       // R3
endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;
    localparam int P      = 40;
    localparam int TRP    = 3;
    localparam int TMRD   = 2;
    localparam int TRFC   = 8;
    localparam int LOCK   = 200;
    localparam int AW     = 13;
    localparam int BW     = 2;
    localparam logic [2:0] BL  = 3'b011;
    localparam logic       BT  = 1'b1;
    localparam logic [2:0] CL  = 3'b110;
    localparam logic       DRV = 1'b1;

    // Expected words from R5..R7
    localparam int W_PRE    = 1 << 10;
    localparam int W_EXT    = int'(DRV) << 1;
    localparam int W_RUN    = (int'(CL) << 4) | (int'(BT) << 3) | int'(BL);
    localparam int W_DLLRST = W_RUN | (1 << 8);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    ddr_pwrup_seq #(
        .PWRUP_CYCLES (P),
        .TRP_CYC      (TRP),
        .TMRD_CYC     (TMRD),
        .TRFC_CYC     (TRFC),
        .LOCK_CYC     (LOCK),
        .ADDR_W       (AW),
        .BANK_W       (BW),
        .BURST_CODE   (BL),
        .BURST_TYPE   (BT),
        .CAS_CODE     (CL),
        .DRV_REDUCED  (DRV)
    ) u0 (
        .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        check(cke == 1'b0, req, cke, 0);
        check(cs_n == 1'b1, req, cs_n, 1);
        check({ras_n, cas_n, we_n} == 3'b111, req, {ras_n, cas_n, we_n}, 7);
        check(init_done == 1'b0, req, init_done, 0);
        check(ba == '0 && addr == '0, req, addr, 0);
    endtask

    // Leaves rst low at a negedge right after the last reset edge
    task automatic apply_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_quiet("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R1 first cycle after release");
    endtask

    task automatic t_full_sequence();
        int kc[7];
        int ca[7];
        int cb[7];
        int cc[7];
        int n = 0;
        int kdone = -1;
        int kcke = -1;
        int exp_k[7];
        int exp_c[7];
        int exp_a[7];
        int exp_b[7];
        bit cs_bad = 0;
        bit cke_fell = 0;
        apply_reset();
        for (int k = 1; k <= P + 2 + 2*TRP + 2*TMRD + 2*TRFC + LOCK + 20; k++) begin
            @(negedge clk);
            if ({ras_n, cas_n, we_n} != 3'b111) begin
                if (n < 7) begin
                    kc[n] = k; cc[n] = {ras_n, cas_n, we_n};
                    ca[n] = int'(addr); cb[n] = int'(ba);
                end
                n++;
            end
            if (cs_n == cke) cs_bad = 1;
            if (kcke < 0 && cke) kcke = k;
            if (kcke >= 0 && !cke) cke_fell = 1;
            if (kdone < 0 && init_done) kdone = k;
            if (k == P) check(cke == 1'b0, "R2 cke low at end of wait", cke, 0);
        end
        check(kcke == P + 1, "R2 cke rise edge", kcke, P + 1);
        check(!cke_fell, "R2 cke stays high", cke_fell, 0);
        check(!cs_bad, "R3 cs_n inverse of cke", cs_bad, 0);
        check(n == 7, "R4 command count", n, 7);
        exp_c = '{3'b010, 3'b000, 3'b000, 3'b010, 3'b001, 3'b001, 3'b000};
        exp_a = '{W_PRE, W_EXT, W_DLLRST, W_PRE, 0, 0, W_RUN};
        exp_b = '{0, 1, 0, 0, 0, 0, 0};
        exp_k[0] = P + 2;
        exp_k[1] = exp_k[0] + TRP;
        exp_k[2] = exp_k[1] + TMRD;
        exp_k[3] = exp_k[2] + TMRD;
        exp_k[4] = exp_k[3] + TRP;
        exp_k[5] = exp_k[4] + TRFC;
        exp_k[6] = exp_k[5] + TRFC;
        if (n == 7) begin
            for (int i = 0; i < 7; i++) begin
                check(cc[i] == exp_c[i], "R4 R3 command code", cc[i], exp_c[i]);
                check(kc[i] == exp_k[i], "R8 command edge", kc[i], exp_k[i]);
                check(cb[i] == exp_b[i], "R6 R7 bank", cb[i], exp_b[i]);
            end
            check(ca[0] == W_PRE && ca[3] == W_PRE, "R5 precharge addr", ca[3], W_PRE);
            check(ca[1] == W_EXT, "R6 ext-mode addr", ca[1], W_EXT);
            check(ca[2] == W_DLLRST, "R7 mode with DLL reset", ca[2], W_DLLRST);
            check(ca[6] == W_RUN, "R7 mode without DLL reset", ca[6], W_RUN);
            check(ca[4] == 0 && ca[5] == 0, "R3 refresh addr", ca[4], 0);
        end
        check(kdone == exp_k[6] + LOCK, "R9 done edge", kdone, exp_k[6] + LOCK);
    endtask

    task automatic t_done_hold();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check(init_done && cke && {ras_n, cas_n, we_n} == 3'b111,
                  "R9 done holds quiet", {init_done, ras_n, cas_n, we_n}, 15);
        end
    endtask

    task automatic t_mid_reset();
        int kpre = -1;
        apply_reset();
        repeat (P + 2 + TRP + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_quiet("R10 reset mid-sequence");
        rst = 1'b0;
        for (int k = 1; k <= P + 2; k++) begin
            @(negedge clk);
            if (k == P) check(cke == 1'b0, "R10 wait replayed", cke, 0);
            if (k == P + 1) check(cke == 1'b1, "R10 cke rise again", cke, 1);
            if (kpre < 0 && {ras_n, cas_n, we_n} != 3'b111) kpre = k;
        end
        check(kpre == P + 2, "R10 first precharge replayed", kpre, P + 2);
        check({ras_n, cas_n, we_n} == 3'b010, "R10 precharge code", {ras_n, cas_n, we_n}, 2);
    endtask

    initial begin
        t_reset_state();
        t_full_sequence();
        t_done_hold();
        t_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule